// File: doc/BRIEF.md
# Two-Channel Sample Input Front End with Interleave Demultiplexer

This block is the digital input stage of a two-channel 14-bit converter. It takes sample words either on two separate ports, one per channel, or on a single fast port that carries I and Q words in alternation. A mode input chooses the arrangement. Every channel passes its data through two register stages. A write strobe loads the first stage. An update strobe copies the first stage into the output register that feeds the converter core.

All logic runs on one clock, `clk`. The write strobes and the update strobes are synchronous enables on that clock. In dual-port mode each channel has its own write strobe and its own update strobe, so the two channels are loaded and refreshed independently. They can also be refreshed on the same edge. In interleaved mode the words arrive on port A, qualified by `wr_a`. Consecutive words are split into an I word and a Q word. A complete pair goes into both first stages at once. A pulse on `upd_a` then moves that pair into both outputs together, so with one update per pair the outputs refresh at half the input word rate.

A sleep input freezes the whole block. Mode changes are applied at a pair boundary, and any half-received pair is thrown away.

Top module: `dacif_front`

## Requirements
- R1: While `rst_n` is low, both outputs read zero, the active mode is dual-port, and the interleave phase is reset.
- R2: In dual-port mode, `wr_a` loads `data_a` into the channel A first stage, and `wr_b` loads `data_b` into the channel B first stage. A write to one channel leaves the other channel unchanged.
- R3: In dual-port mode, an output changes only on the clock edge where that channel's update strobe is high. On that edge it takes the first-stage value, and it is visible after that edge.
- R4: When a channel's write and update strobes are both high in the same cycle, the output takes the previous first-stage value. The new word reaches the output only at a later update.
- R5: The update strobes of the two channels act independently. Both outputs refresh on the same edge when both strobes are high.
- R6: In interleaved mode (`mode_il` = 1), words arrive on `data_a` qualified by `wr_a`. The first word after reset or after a mode change is I and goes to `out_a`. The next word is Q and goes to `out_b`, and the sequence keeps alternating. `wr_b`, `data_b` and `upd_b` have no effect in this mode.
- R7: In interleaved mode, `upd_a` moves the last complete pair to both outputs on the same edge, and it does so once per pair. If a pair completes in the same cycle as `upd_a`, the outputs take the older pair and the new pair waits for the next update.
- R8: In interleaved mode, an I word whose Q word has not yet arrived never reaches an output. An update with no complete pair pending leaves both outputs unchanged.
- R9: When `mode_il` differs from the active mode, that cycle is a switch cycle. In a switch cycle no write or update takes effect, a half-received pair and any pending pair are dropped, and the new mode is active from the next cycle.
- R10: While `sleep` is high, the outputs, the first stages, the interleave phase and the active mode all hold, whatever the strobes, data and mode input do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_il | input | 1 | 0 selects dual-port mode, 1 selects interleaved mode |
| sleep | input | 1 | Freezes all state while high |
| wr_a | input | 1 | Port A write strobe; in interleaved mode, the word strobe |
| data_a | input | 14 | Port A sample word; in interleaved mode, the I/Q stream |
| upd_a | input | 1 | Channel A update strobe; in interleaved mode, the pair update |
| wr_b | input | 1 | Port B write strobe (dual-port mode only) |
| data_b | input | 14 | Port B sample word (dual-port mode only) |
| upd_b | input | 1 | Channel B update strobe (dual-port mode only) |
| out_a | output | 14 | Channel A (I) output register |
| out_b | output | 14 | Channel B (Q) output register |

## Verification
The main collision is a write and an update in the same cycle. In dual-port mode the bench raises a channel's write and update strobes together, and expects the output to take the older word first and the new word only on the following update. In interleaved mode the bench makes the Q word of a new pair arrive in the same cycle as `upd_a`. It expects the older pair at the outputs and the new pair one update later. A behavioural model built from queues judges every cycle, including a pseudo-random phase that mixes mode changes and sleep with the strobes.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int SAMPLE_W = 14;
  localparam int NUM_CH   = 2;

  typedef enum logic {
    MODE_DUAL = 1'b0,
    MODE_ILV  = 1'b1
  } dac_mode_e;
endpackage

// File: rtl/dacif_channel.sv
module dacif_channel #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_in,
  input  logic [W-1:0] d_in,
  input  logic         ld_out,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage_q, stage_n;
  logic [W-1:0] out_q, out_n;

  // next state: the output copies the stage before the stage is overwritten
  always_comb begin
    stage_n = stage_q;
    out_n   = out_q;
    if (ld_out) out_n   = stage_q;
    if (ld_in)  stage_n = d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      stage_q <= stage_n;
      out_q   <= out_n;
    end
  end

  assign q_out = out_q;

  // R4
  xfer_old_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_out |=> out_q == $past(stage_q));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_out |=> $stable(out_q));

  // R2
  stage_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_in |=> stage_q == $past(d_in));
endmodule

// File: rtl/dacif_ilv_demux.sv
module dacif_ilv_demux #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         upd,
  output logic         pair_ld,
  output logic [W-1:0] pair_i,
  output logic [W-1:0] pair_q,
  output logic         xfer
);
  logic         phase_q, phase_n;
  logic         pend_q, pend_n;
  logic [W-1:0] hold_q, hold_n;

  assign pair_ld = en && wr && phase_q;
  assign pair_i  = hold_q;
  assign pair_q  = din;
  assign xfer    = en && upd && pend_q;

  always_comb begin
    phase_n = phase_q;
    pend_n  = pend_q;
    hold_n  = hold_q;
    if (clr) begin
      phase_n = 1'b0;
      pend_n  = 1'b0;
    end else if (en) begin
      if (wr) begin
        if (!phase_q) hold_n = din;
        phase_n = !phase_q;
      end
      if (pair_ld)   pend_n = 1'b1;
      else if (xfer) pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      pend_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      phase_q <= phase_n;
      pend_q  <= pend_n;
      hold_q  <= hold_n;
    end
  end

  // R9
  switch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !phase_q && !pend_q);

  // R6
  i_word_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && wr && !phase_q) |=> phase_q && hold_q == $past(din));

  // R7
  single_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !pair_ld && !clr) |=> !pend_q);
endmodule

// File: rtl/dacif_front.sv
module dacif_front
  import dacif_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_il,
  input  logic         sleep,
  input  logic         wr_a,
  input  logic [W-1:0] data_a,
  input  logic         upd_a,
  input  logic         wr_b,
  input  logic [W-1:0] data_b,
  input  logic         upd_b,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b
);
  localparam int NCH = NUM_CH;

  dac_mode_e mode_q, mode_n, mode_req;
  logic      switching, run, dual_run, ilv_run;
  logic      pair_ld, xfer;
  logic [W-1:0] pair_i, pair_q;

  logic [NCH-1:0] wr_v, upd_v, ld_in_v, ld_out_v;
  logic [W-1:0]   din_v  [NCH];
  logic [W-1:0]   dsel_v [NCH];
  logic [W-1:0]   q_v    [NCH];

  assign mode_req  = mode_il ? MODE_ILV : MODE_DUAL;
  assign switching = !sleep && (mode_req != mode_q);
  assign run       = !sleep && !switching;
  assign dual_run  = run && (mode_q == MODE_DUAL);
  assign ilv_run   = run && (mode_q == MODE_ILV);

  always_comb begin
    mode_n = mode_q;
    if (!sleep) mode_n = mode_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_DUAL;
    else        mode_q <= mode_n;
  end

  assign wr_v     = {wr_b, wr_a};
  assign upd_v    = {upd_b, upd_a};
  assign din_v[0] = data_a;
  assign din_v[1] = data_b;

  dacif_ilv_demux #(.W(W)) u_demux (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ilv_run),
    .clr     (switching),
    .wr      (wr_a),
    .din     (data_a),
    .upd     (upd_a),
    .pair_ld (pair_ld),
    .pair_i  (pair_i),
    .pair_q  (pair_q),
    .xfer    (xfer)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_comb begin
      if (dual_run) begin
        ld_in_v[ch]  = wr_v[ch];
        ld_out_v[ch] = upd_v[ch];
        dsel_v[ch]   = din_v[ch];
      end else begin
        ld_in_v[ch]  = pair_ld;
        ld_out_v[ch] = xfer;
        dsel_v[ch]   = (ch == 0) ? pair_i : pair_q;
      end
    end

    dacif_channel #(.W(W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_in  (ld_in_v[ch]),
      .d_in   (dsel_v[ch]),
      .ld_out (ld_out_v[ch]),
      .q_out  (q_v[ch])
    );
  end

  assign out_a = q_v[0];
  assign out_b = q_v[1];

  // R10
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(out_a) && $stable(out_b) && $stable(mode_q));

  // R9
  switch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switching |=> $stable(out_a) && $stable(out_b));

  // R9
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> mode_q == $past(mode_req));

  // R3
  dual_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_run && !upd_a) |=> $stable(out_a));

  // R6
  ilv_b_port_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ilv_run && !upd_a) |=> $stable(out_a) && $stable(out_b));
endmodule

// File: tb/dacif_front_bench.sv
`timescale 1ns/1ps
module dacif_front_bench;
  localparam int W = 14;

  logic clk = 1'b0;
  logic rst_n, mode_il, sleep, wr_a, upd_a, wr_b, upd_b;
  logic [W-1:0] data_a, data_b, out_a, out_b;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit cmp_en = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_mode, m_pend, m_sa, m_sb, m_oa, m_ob;
  int half[$];

  always #4 clk = ~clk;

  dacif_front u_dacif_front (
    .clk(clk), .rst_n(rst_n), .mode_il(mode_il), .sleep(sleep),
    .wr_a(wr_a), .data_a(data_a), .upd_a(upd_a),
    .wr_b(wr_b), .data_b(data_b), .upd_b(upd_b),
    .out_a(out_a), .out_b(out_b)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pend = 0; m_sa = 0; m_sb = 0; m_oa = 0; m_ob = 0;
      half.delete();
    end else if (!sleep) begin
      if (int'(mode_il) != m_mode) begin
        m_mode = int'(mode_il);
        half.delete();
        m_pend = 0;
      end else if (m_mode == 0) begin
        if (upd_a) m_oa = m_sa;
        if (upd_b) m_ob = m_sb;
        if (wr_a) m_sa = int'(data_a);
        if (wr_b) m_sb = int'(data_b);
      end else begin
        if (upd_a && m_pend != 0) begin
          m_oa = m_sa; m_ob = m_sb; m_pend = 0;
        end
        if (wr_a) begin
          half.push_back(int'(data_a));
          if (half.size() == 2) begin
            m_sa = half[0]; m_sb = half[1];
            half.delete();
            m_pend = 1;
          end
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk(cur_req, int'(out_a), m_oa);
      chk(cur_req, int'(out_b), m_ob);
    end
  end

  task automatic cyc(input bit wa, input int da, input bit ua,
                     input bit wb, input int db, input bit ub);
    wr_a = wa; data_a = W'(da); upd_a = ua;
    wr_b = wb; data_b = W'(db); upd_b = ub;
    @(posedge clk);
    @(negedge clk);
    wr_a = 0; upd_a = 0; wr_b = 0; upd_b = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; mode_il = 0; sleep = 0;
    wr_a = 0; upd_a = 0; wr_b = 0; upd_b = 0; data_a = '0; data_b = '0;
    repeat (3) @(negedge clk);
    // R1: outputs zero in reset
    chk("R1", int'(out_a), 0);
    chk("R1", int'(out_b), 0);
    rst_n = 1;
    cmp_en = 1;

    // R2 R3: write only, then update
    cur_req = "R3";
    cyc(1, 'h1234, 0, 0, 0, 0);
    chk("R3", int'(out_a), 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R2", int'(out_a), 'h1234);
    chk("R2", int'(out_b), 0);

    // R4: write and update in one cycle
    cur_req = "R4";
    cyc(1, 'h2222, 0, 0, 0, 0);
    cyc(1, 'h3333, 1, 0, 0, 0);
    chk("R4", int'(out_a), 'h2222);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R4", int'(out_a), 'h3333);

    // R5: independent and simultaneous updates
    cur_req = "R5";
    cyc(0, 0, 0, 1, 'h0BBB, 0);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R5", int'(out_b), 'h0BBB);
    chk("R5", int'(out_a), 'h3333);
    cyc(1, 'h0111, 0, 1, 'h0222, 0);
    cyc(0, 0, 1, 0, 0, 1);
    chk("R5", int'(out_a), 'h0111);
    chk("R5", int'(out_b), 'h0222);

    // R9: switch cycle ignores strobes
    cur_req = "R9";
    mode_il = 1;
    cyc(1, 'h3FFF, 1, 1, 'h3EEE, 1);
    chk("R9", int'(out_a), 'h0111);
    chk("R9", int'(out_b), 'h0222);

    // R6: I then Q, port B ignored
    cur_req = "R6";
    cyc(1, 'h0101, 0, 1, 'h3AAA, 1);
    cyc(1, 'h0202, 0, 1, 'h3BBB, 1);
    chk("R6", int'(out_a), 'h0111);
    chk("R6", int'(out_b), 'h0222);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R6", int'(out_a), 'h0101);
    chk("R6", int'(out_b), 'h0202);

    // R8: half pair never reaches output
    cur_req = "R8";
    cyc(1, 'h0303, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R8", int'(out_a), 'h0101);
    chk("R8", int'(out_b), 'h0202);
    cyc(1, 'h0404, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R8", int'(out_a), 'h0303);
    chk("R8", int'(out_b), 'h0404);

    // R7: pair completes in the same cycle as an update
    cur_req = "R7";
    cyc(1, 'h0505, 0, 0, 0, 0);
    cyc(1, 'h0606, 0, 0, 0, 0);
    cyc(1, 'h0707, 0, 0, 0, 0);
    cyc(1, 'h0808, 1, 0, 0, 0);
    chk("R7", int'(out_a), 'h0505);
    chk("R7", int'(out_b), 'h0606);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R7", int'(out_a), 'h0707);
    chk("R7", int'(out_b), 'h0808);

    // R9: half pair dropped across a mode change
    cur_req = "R9";
    cyc(1, 'h0909, 0, 0, 0, 0);
    mode_il = 0;
    cyc(0, 0, 0, 0, 0, 0);
    mode_il = 1;
    cyc(0, 0, 0, 0, 0, 0);
    cyc(1, 'h0A0A, 0, 0, 0, 0);
    cyc(1, 'h0B0B, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R9", int'(out_a), 'h0A0A);
    chk("R9", int'(out_b), 'h0B0B);

    // R10: sleep freezes outputs, stages, phase and mode
    cur_req = "R10";
    cyc(1, 'h0C0C, 0, 0, 0, 0);
    sleep = 1; mode_il = 0;
    cyc(1, 'h0D0D, 1, 1, 'h0D0D, 1);
    cyc(1, 'h0D1D, 1, 1, 'h0D1D, 1);
    chk("R10", int'(out_a), 'h0A0A);
    chk("R10", int'(out_b), 'h0B0B);
    sleep = 0; mode_il = 1;
    cyc(1, 'h0E0E, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R10", int'(out_a), 'h0C0C);
    chk("R10", int'(out_b), 'h0E0E);

    // mixed pseudo-random traffic judged by the model every cycle
    cur_req = "R7";
    begin
      logic [31:0] lf;
      lf = 32'hACE1_2468;
      for (int i = 0; i < 600; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        mode_il = (i < 300) ? (lf[9:5] == 0 ? ~mode_il : mode_il) : lf[20];
        sleep = (lf[12:10] == 3'd0);
        cyc(lf[0], int'(lf[24:11]), lf[1], lf[2], int'(lf[31:18]), lf[3]);
      end
    end
    sleep = 0;
    cyc(0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule